// File: doc/BRIEF.md
# Double-Indexed Frame Read Address Generator

This block is the address side of a display-refresh read channel. Software fills a programmed register set through a small 16-bit register port. That set holds the start and end addresses of a framebuffer region, the element size, the number of elements per frame, the number of frames, and signed element and frame indices. Writing the end-of-programming bit moves the programmed set into an active set, which the channel then walks. It issues one read request per element on a request/acknowledge memory port.

Two walk modes exist. The linear mode steps by the element size from the top address up to the bottom address. The double-indexed mode adds a signed correction after every element and a second signed correction after the last element of each frame. Rotated or mirrored traversal of a picture is programmed through these corrections. When the programmed set is committed during a block, the active set stays untouched until the next block begins.

A block can run once, or restart from the top address after each block. A sticky block-complete flag can raise an interrupt.

Top module: `frame_dma_agen`

Register offsets: 0 top upper half, 1 top lower half, 2 bottom upper half, 3 bottom lower half, 4 element count, 5 frame count, 6 element index, 7 frame index upper half, 8 frame index lower half, 9 configuration, 10 control. Reads of any other offset return 0.

## Requirements
- R1: After reset, mem_req and irq are 0, and the control and configuration registers read 0.
- R2: Configuration bits [1:0] select the element size: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.
- R3: With configuration bit 2 clear (linear mode), the channel requests top, top+size, top+2·size and so on. The request at the bottom address ends the block.
- R4: With configuration bit 2 set (double-indexed mode), an element that is not the last of its frame is followed by address + size + EI − 1. EI is the 16-bit element index at offset 6, read as a signed value.
- R5: In double-indexed mode, the last element of a frame is followed by address + size + FI − 1, where FI is the signed 32-bit frame index. A block is element count × frame count requests, and a count of 0 acts as 1.
- R6: The 32-bit top, bottom and frame-index values are each written as an upper and a lower 16-bit half. Every programmed register reads back the value written to it.
- R7: Register writes change only the programmed set. Writing 1 to control bit 4 (end of programming) copies the programmed set into the active set at once when the channel is idle. During a block it marks the copy pending (control bit 4 reads 1), and the copy happens at the next block start. The running block keeps its old values.
- R8: With configuration bit 3 (repeat) set, the request that follows the last one of a block is the top address, with no idle cycle. With repeat clear, the channel stops after one block and stays idle, even while enabled, until end of programming is written again.
- R9: Control bit 3 becomes 1 when a block completes. Writing 1 to it clears it, and a completion in the same cycle wins. irq is control bit 3 AND control bit 1 (interrupt enable).
- R10: Control bit 0 enables the channel. Clearing it lets the request in flight finish and then issues no further requests. Enabling again restarts from the top address.
- R11: A request holds mem_req high and mem_addr unchanged until mem_ack is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Byte address of the requested element |
| mem_ack | input | 1 | Request accepted in this cycle |
| irq | output | 1 | Block-complete interrupt |

## Verification
Some rules are checked on every cycle by the assertions:
- an unacknowledged request stays stable;
- a disabled, quiet channel stays quiet;
- linear steps equal the element size;
- the element counter stays in range;
- the active set never changes in the middle of a block;
- the complete flag rises only on a block end;
- a clear write drops irq.

Other behaviour needs the bench's scenarios:
- the full address sequences for each element size and for signed element and frame indices;
- when a pending copy takes effect relative to block boundaries;
- the restart with repeat and the idle state after a single block;
- the exact point where disabling stops the stream.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int REG_W  = 16;
  localparam int EIDX_W = 16;

  localparam int OFS_TOP_HI = 0;
  localparam int OFS_TOP_LO = 1;
  localparam int OFS_BOT_HI = 2;
  localparam int OFS_BOT_LO = 3;
  localparam int OFS_NELEM  = 4;
  localparam int OFS_NFRAME = 5;
  localparam int OFS_EIDX   = 6;
  localparam int OFS_FIDX_HI = 7;
  localparam int OFS_FIDX_LO = 8;
  localparam int OFS_CFG    = 9;
  localparam int OFS_CTRL   = 10;

  typedef struct packed {
    logic [ADDR_W-1:0] top;
    logic [ADDR_W-1:0] bot;
    logic [CNT_W-1:0]  nelem;
    logic [CNT_W-1:0]  nframe;
    logic [EIDX_W-1:0] eidx;
    logic [ADDR_W-1:0] fidx;
    logic [1:0]        dtype;
    logic              dbl;
    logic              rpt;
  } chan_set_t;

  function automatic logic [2:0] elem_bytes(input logic [1:0] dt);
    case (dt)
      2'd0:    elem_bytes = 3'd1;
      2'd1:    elem_bytes = 3'd2;
      default: elem_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/fdma_rst_sync.sv
module fdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= 1'b1;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fdma_step.sv
module fdma_step #(
  parameter int AW  = 32,
  parameter int EIW = 16
) (
  input  logic [AW-1:0]  cur_i,
  input  logic [2:0]     es_i,
  input  logic [EIW-1:0] eidx_i,
  input  logic [AW-1:0]  fidx_i,
  input  logic           dbl_i,
  input  logic           wrap_i,
  output logic [AW-1:0]  nxt_o
);
  logic [AW-1:0] es_w;
  logic [AW-1:0] ei_w;
  logic [AW-1:0] idx_w;

  always_comb begin
    es_w  = {{(AW-3){1'b0}}, es_i};
    ei_w  = {{(AW-EIW){eidx_i[EIW-1]}}, eidx_i};
    idx_w = wrap_i ? fidx_i : ei_w;
    if (dbl_i) nxt_o = cur_i + es_w + idx_w - {{(AW-1){1'b0}}, 1'b1};
    else       nxt_o = cur_i + es_w;
  end
endmodule

// File: rtl/fdma_regs.sv
module fdma_regs
  import fdma_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              start_i,
  input  logic              blk_end_i,
  input  logic              busy_i,
  output chan_set_t         act_o,
  output logic [ADDR_W-1:0] top_next_o,
  output logic              en_o,
  output logic              armed_o,
  output logic              irq_o
);
  chan_set_t prog_q, prog_d;
  chan_set_t act_q, act_d;
  logic en_q, en_d, irqen_q, irqen_d, done_q, done_d;
  logic pend_q, pend_d, armed_q, armed_d;
  logic ctrl_wr, endprog_wr, copy, use_prog;

  always_comb begin
    prog_d = prog_q;
    if (we_i) begin
      case (int'(addr_i))
        OFS_TOP_HI:  prog_d.top[31:16]  = wdata_i;
        OFS_TOP_LO:  prog_d.top[15:0]   = wdata_i;
        OFS_BOT_HI:  prog_d.bot[31:16]  = wdata_i;
        OFS_BOT_LO:  prog_d.bot[15:0]   = wdata_i;
        OFS_NELEM:   prog_d.nelem       = wdata_i;
        OFS_NFRAME:  prog_d.nframe      = wdata_i;
        OFS_EIDX:    prog_d.eidx        = wdata_i;
        OFS_FIDX_HI: prog_d.fidx[31:16] = wdata_i;
        OFS_FIDX_LO: prog_d.fidx[15:0]  = wdata_i;
        OFS_CFG: begin
          prog_d.dtype = wdata_i[1:0];
          prog_d.dbl   = wdata_i[2];
          prog_d.rpt   = wdata_i[3];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_wr    = we_i && (int'(addr_i) == OFS_CTRL);
    endprog_wr = ctrl_wr && wdata_i[4];
    en_d       = ctrl_wr ? wdata_i[0] : en_q;
    irqen_d    = ctrl_wr ? wdata_i[1] : irqen_q;
    done_d     = done_q;
    if (ctrl_wr && wdata_i[3]) done_d = 1'b0;
    if (blk_end_i)             done_d = 1'b1;
    use_prog   = pend_q || endprog_wr;
    copy       = (endprog_wr && (!busy_i || start_i)) || (start_i && pend_q);
    act_d      = copy ? prog_q : act_q;
    pend_d     = pend_q;
    if (start_i) pend_d = 1'b0;
    if (endprog_wr && busy_i && !start_i) pend_d = 1'b1;
    armed_d    = armed_q;
    if (blk_end_i && !act_q.rpt) armed_d = 1'b0;
    if (endprog_wr)              armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= '0;
      act_q   <= '0;
      en_q    <= 1'b0;
      irqen_q <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prog_q  <= prog_d;
      act_q   <= act_d;
      en_q    <= en_d;
      irqen_q <= irqen_d;
      done_q  <= done_d;
      pend_q  <= pend_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    case (int'(addr_i))
      OFS_TOP_HI:  rdata_o = prog_q.top[31:16];
      OFS_TOP_LO:  rdata_o = prog_q.top[15:0];
      OFS_BOT_HI:  rdata_o = prog_q.bot[31:16];
      OFS_BOT_LO:  rdata_o = prog_q.bot[15:0];
      OFS_NELEM:   rdata_o = prog_q.nelem;
      OFS_NFRAME:  rdata_o = prog_q.nframe;
      OFS_EIDX:    rdata_o = prog_q.eidx;
      OFS_FIDX_HI: rdata_o = prog_q.fidx[31:16];
      OFS_FIDX_LO: rdata_o = prog_q.fidx[15:0];
      OFS_CFG:     rdata_o = {12'd0, prog_q.rpt, prog_q.dbl, prog_q.dtype};
      OFS_CTRL:    rdata_o = {11'd0, pend_q, done_q, 1'b0, irqen_q, en_q};
      default:     rdata_o = '0;
    endcase
  end

  assign act_o      = act_q;
  assign top_next_o = use_prog ? prog_q.top : act_q.top;
  assign en_o       = en_q;
  assign armed_o    = armed_q;
  assign irq_o      = done_q && irqen_q;

  AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && !start_i |=> $stable(act_q)); // R7
  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(blk_end_i)); // R9
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata_i[3] && !blk_end_i |=> !irq_o); // R9
endmodule

// File: rtl/fdma_walker.sv
module fdma_walker
  import fdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              armed_i,
  input  chan_set_t         act_i,
  input  logic [ADDR_W-1:0] top_next_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              start_o,
  output logic              blk_end_o,
  output logic              busy_o
);
  logic              run_q, run_d;
  logic [ADDR_W-1:0] addr_q, addr_d, step_addr, es_ext;
  logic [CNT_W-1:0]  ecnt_q, ecnt_d, fcnt_q, fcnt_d;
  logic [2:0]        es;
  logic              fire, last_elem, last_frame, blk_last, launch, restart, start;

  always_comb begin
    es         = elem_bytes(act_i.dtype);
    es_ext     = {{(ADDR_W-3){1'b0}}, es};
    fire       = run_q && mem_ack_i;
    last_elem  = ecnt_q >= act_i.nelem;
    last_frame = fcnt_q >= act_i.nframe;
    blk_last   = act_i.dbl ? (last_elem && last_frame) : (addr_q == act_i.bot);
    launch     = !run_q && en_i && armed_i;
    restart    = fire && blk_last && act_i.rpt && en_i;
    start      = launch || restart;
  end

  fdma_step #(.AW(ADDR_W), .EIW(EIDX_W)) u_step (
    .cur_i  (addr_q),
    .es_i   (es),
    .eidx_i (act_i.eidx),
    .fidx_i (act_i.fidx),
    .dbl_i  (act_i.dbl),
    .wrap_i (last_elem),
    .nxt_o  (step_addr)
  );

  always_comb begin
    run_d  = run_q;
    addr_d = addr_q;
    ecnt_d = ecnt_q;
    fcnt_d = fcnt_q;
    if (start) begin
      run_d  = 1'b1;
      addr_d = top_next_i;
      ecnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
      fcnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (fire) begin
      if (blk_last || !en_i) begin
        run_d = 1'b0;
      end else begin
        addr_d = step_addr;
        if (act_i.dbl) begin
          if (last_elem) begin
            ecnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
            fcnt_d = fcnt_q + 1'b1;
          end else begin
            ecnt_d = ecnt_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      addr_q <= '0;
      ecnt_q <= '0;
      fcnt_q <= '0;
    end else begin
      run_q  <= run_d;
      if (start || fire) begin
        addr_q <= addr_d;
        ecnt_q <= ecnt_d;
        fcnt_q <= fcnt_d;
      end
    end
  end

  assign mem_req_o  = run_q;
  assign mem_addr_o = addr_q;
  assign start_o    = start;
  assign blk_end_o  = fire && blk_last;
  assign busy_o     = run_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R11
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i && !mem_req_o |=> !mem_req_o); // R10
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !act_i.dbl && !blk_last && en_i |=>
      mem_addr_o == $past(mem_addr_o) + $past(es_ext)); // R3
  AST_ECNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && act_i.dbl && act_i.nelem != '0 |-> ecnt_q <= act_i.nelem); // R5
endmodule

// File: rtl/frame_dma_agen.sv
module frame_dma_agen
  import fdma_pkg::*;
#(
  parameter int REG_AW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  output logic              irq
);
  logic              rst_s_n;
  chan_set_t         act;
  logic [ADDR_W-1:0] top_next;
  logic              en, armed, start, blk_end, busy;

  fdma_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  fdma_regs #(.REG_AW(REG_AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .we_i       (reg_we),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .start_i    (start),
    .blk_end_i  (blk_end),
    .busy_i     (busy),
    .act_o      (act),
    .top_next_o (top_next),
    .en_o       (en),
    .armed_o    (armed),
    .irq_o      (irq)
  );

  fdma_walker u_walk (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .en_i       (en),
    .armed_i    (armed),
    .act_i      (act),
    .top_next_i (top_next),
    .mem_ack_i  (mem_ack),
    .mem_req_o  (mem_req),
    .mem_addr_o (mem_addr),
    .start_o    (start),
    .blk_end_o  (blk_end),
    .busy_o     (busy)
  );
endmodule

// File: tb/frame_dma_agen_test.sv
`timescale 1ns/1ps
module frame_dma_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] log_a [0:63];
  logic [31:0] exp_a [0:63];
  int n_log = 0;
  int n_exp = 0;
  bit cap_on = 0;
  bit ack_en = 1;

  always #10 clk = ~clk;

  frame_dma_agen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
  );

  always @(negedge clk) begin
    if (cap_on && mem_req && ack_en && n_log < 64) begin
      log_a[n_log] = mem_addr;
      n_log++;
    end
    mem_ack = ack_en && mem_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = reg_rdata;
  endtask

  task automatic prog(input logic [31:0] top, input logic [31:0] bot,
                      input logic [15:0] ne, input logic [15:0] nf,
                      input logic [15:0] ei, input logic [31:0] fi,
                      input logic [15:0] cfg);
    wr(0, top[31:16]); wr(1, top[15:0]);
    wr(2, bot[31:16]); wr(3, bot[15:0]);
    wr(4, ne); wr(5, nf); wr(6, ei);
    wr(7, fi[31:16]); wr(8, fi[15:0]);
    wr(9, cfg);
  endtask

  function automatic logic [31:0] esz(input logic [1:0] dt);
    return (dt == 2'd0) ? 32'd1 : (dt == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  task automatic build_lin(input logic [31:0] top, input logic [31:0] bot, input logic [1:0] dt);
    logic [31:0] a;
    a = top; n_exp = 0;
    while (a != bot && n_exp < 63) begin
      exp_a[n_exp] = a; n_exp++; a = a + esz(dt);
    end
    exp_a[n_exp] = bot; n_exp++;
  endtask

  task automatic build_dbl(input logic [31:0] top, input logic [1:0] dt,
                           input int ne, input int nf,
                           input logic [15:0] ei, input logic [31:0] fi);
    logic [31:0] a;
    a = top; n_exp = 0;
    for (int f = 0; f < nf; f++) begin
      for (int e = 0; e < ne; e++) begin
        exp_a[n_exp] = a; n_exp++;
        if (e < ne - 1) a = a + esz(dt) + {{16{ei[15]}}, ei} - 32'd1;
        else            a = a + esz(dt) + fi - 32'd1;
      end
    end
  endtask

  task automatic cmp_log(input string tag);
    chk({tag, " count"}, 32'(n_log), 32'(n_exp));
    for (int i = 0; i < n_exp && i < n_log; i++) chk(tag, log_a[i], exp_a[i]);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_chan();
    wr(10, 16'h0008);
    wait_cyc(6);
    cap_on = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(10, d); chk("R1 ctrl", 32'(d), 0);
    rd(9, d);  chk("R1 cfg", 32'(d), 0);
  endtask

  task automatic t_linear16();
    logic [15:0] d;
    prog(32'h0000_1000, 32'h0000_1006, 16'd1, 16'd1, 16'd0, 32'd0, 16'h0001);
    n_log = 0; cap_on = 1;
    wr(10, 16'h0011);
    wait_cyc(20);
    build_lin(32'h1000, 32'h1006, 2'd1);
    cmp_log("R3 R2 linear16");
    rd(10, d); chk("R9 done set, no irq enable", 32'(d), 32'h0009);
    chk("R9 irq gated", 32'(irq), 0);
    wait_cyc(10);
    chk("R8 single block stays idle", 32'(n_log), 32'(n_exp));
    chk("R8 no request after single", 32'(mem_req), 0);
  endtask

  task automatic t_irq8();
    logic [15:0] d;
    wr(10, 16'h000B);
    wait_cyc(2);
    chk("R9 irq after clear", 32'(irq), 0);
    prog(32'h0000_0010, 32'h0000_0013, 16'd1, 16'd1, 16'd0, 32'd0, 16'h0000);
    n_log = 0; cap_on = 1;
    wr(10, 16'h0013);
    wait_cyc(15);
    build_lin(32'h10, 32'h13, 2'd0);
    cmp_log("R2 linear8");
    chk("R9 irq raised", 32'(irq), 1);
    wr(10, 16'h000A);
    #1 chk("R9 irq after W1C", 32'(irq), 0);
    rd(10, d); chk("R9 ctrl after W1C", 32'(d), 32'h0002);
    cap_on = 0;
  endtask

  task automatic t_dbl32();
    logic [15:0] d;
    prog(32'h0001_2000, 32'h0, 16'd3, 16'd2, 16'hFFF9, 32'h0000_0011, 16'h0006);
    rd(0, d); chk("R6 top upper readback", 32'(d), 32'h0001);
    rd(8, d); chk("R6 fidx lower readback", 32'(d), 32'h0011);
    n_log = 0; cap_on = 1;
    wr(10, 16'h0011);
    wait_cyc(20);
    build_dbl(32'h0001_2000, 2'd2, 3, 2, 16'hFFF9, 32'h11);
    cmp_log("R4 R5 dbl32");
    stop_chan();
  endtask

  task automatic t_dbl_neg_frame();
    prog(32'h0000_8000, 32'h0, 16'd2, 16'd3, 16'h0001, 32'hFFFF_FFF0, 16'h0007);
    n_log = 0; cap_on = 1;
    wr(10, 16'h0011);
    wait_cyc(20);
    build_dbl(32'h8000, 2'd3, 2, 3, 16'h0001, 32'hFFFF_FFF0);
    cmp_log("R5 R2 dbl negative frame index");
    stop_chan();
  endtask

  task automatic t_hold();
    bit ok;
    ack_en = 0;
    prog(32'h0000_3000, 32'h0000_3002, 16'd1, 16'd1, 16'd0, 32'd0, 16'h0001);
    n_log = 0; cap_on = 1;
    wr(10, 16'h0011);
    wait_cyc(2);
    ok = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!(mem_req === 1'b1 && mem_addr === 32'h3000)) ok = 0;
    end
    chk("R11 request held without ack", 32'(ok), 1);
    ack_en = 1;
    wait_cyc(10);
    build_lin(32'h3000, 32'h3002, 2'd1);
    cmp_log("R11 after ack");
    stop_chan();
  endtask

  task automatic t_shadow_repeat();
    int k, bad, frozen;
    logic [15:0] d;
    prog(32'h0000_0100, 32'h0000_0102, 16'd1, 16'd1, 16'd0, 32'd0, 16'h0009);
    n_log = 0; cap_on = 1;
    wr(10, 16'h0011);
    wait_cyc(8);
    wr(1, 16'h0200);
    wr(3, 16'h0206);
    wr(10, 16'h0011);
    #1 d = reg_rdata;
    wait_cyc(14);
    wr(10, 16'h0000);
    wait_cyc(4);
    frozen = n_log;
    chk("R10 no request after disable", 32'(mem_req), 0);
    wait_cyc(8);
    chk("R10 stream frozen", 32'(n_log), 32'(frozen));
    k = -1;
    for (int i = 0; i < n_log; i++) if (k < 0 && log_a[i] == 32'h200) k = i;
    chk("R7 new set reached", 32'(k > 0), 1);
    chk("R7 switch on block boundary", 32'(k % 2), 0);
    bad = 0;
    for (int i = 0; i < n_log; i++) begin
      if (k > 0 && i < k) begin
        if (log_a[i] != ((i % 2 == 0) ? 32'h100 : 32'h102)) bad++;
      end else if (k > 0) begin
        if (log_a[i] != 32'h200 + 32'(2 * ((i - k) % 4))) bad++;
      end
    end
    chk("R8 R7 repeat sequence", 32'(bad), 0);
    chk("R8 repeated several blocks", 32'(k >= 4), 1);
    cap_on = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_linear16();
    t_irq8();
    t_dbl32();
    t_dbl_neg_frame();
    t_hold();
    t_shadow_repeat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule